// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block connects a synchronous request port to an external asynchronous 16-bit static RAM. A requester offers a word address, write data, a two-bit byte-lane mask and a read/write flag under a valid/ready handshake. The controller turns each accepted request into one access on the memory pins: a pair of chip selects of opposite polarity, an active-low write strobe, an active-low output enable, one active-low enable per byte lane, and a data bus split into an output value, a drive enable and an input value for a tri-state pad.

All timing is expressed as counts of clock cycles set by parameters: the write-strobe width, the gap the controller leaves after the write strobe falls before it drives the bus (the memory may still be driving while its output enable is low), the data setup before the strobe rises, and the read access time. All memory-side outputs come straight from registers, so they change only on clock edges. After reset the controller refuses every request until a power-up counter has expired. Read data is captured from the bus at the end of the access and returned with a one-cycle valid pulse.

Top module: `sram_async_ctrl`

## Requirements
- R1: The memory counts as selected only when `mem_ce_n` is 0 and `mem_ce` is 1. Outside an access the controller deselects it (`mem_ce_n`=1, `mem_ce`=0) with `mem_we_n`, `mem_oe_n` and both `mem_be_n` bits at 1 and the bus not driven.
- R2: After reset is released, `req_ready` stays low for exactly `PWR_CYC` cycles and no request is accepted during that time.
- R3: `mem_be_n[0]` enables data bits 7:0 and `mem_be_n[1]` bits 15:8. During an access bit i is 0 exactly when `req_mask[i]` of the accepted request was 1, for reads and writes alike; a mask of 00 leaves the memory contents unchanged.
- R4: A write holds `mem_we_n` low for WE_LEN = max(`WE_CYC`, `TURN_CYC`+`SETUP_CYC`) consecutive cycles with the part selected and `mem_oe_n` low, and `mem_addr` and `mem_be_n` stay stable for the whole strobe.
- R5: During a write the bus is first driven `TURN_CYC` cycles after `mem_we_n` falls and stays driven until the strobe ends, so it carries the request's write data for at least `SETUP_CYC` cycles before `mem_we_n` rises.
- R6: `mem_dq_oe` falls in the same cycle that `mem_we_n` rises, and the bus is never driven while `mem_we_n` is 1.
- R7: A read holds `mem_we_n` high and `mem_oe_n` low with the part selected for `RD_CYC` cycles; in the cycle after that, `rd_valid` is 1 for exactly one cycle and `rd_data` holds the sampled bus with lanes that were not in the mask set to zero.
- R8: `req_ready` is 1 only when the controller is idle and the power-up wait has ended; a request accepted at a clock edge puts the access on the pins from that edge, and `req_valid` during an access has no effect.
- R9: Data written through the controller, including single-lane writes that merge into an existing word, is returned by a later read of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted at the next edge when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/8 | Byte lanes to access, bit 0 = bits 7:0 |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DW | Read data, unmasked lanes zero |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | DW/8 | Active-low byte-lane enables |
| mem_dq_out | output | DW | Value for the bus pad |
| mem_dq_oe | output | 1 | Pad drive enable |
| mem_dq_in | input | DW | Value seen on the bus |

## Verification
Two events share one cycle whenever requests arrive back to back: the end of a write strobe, where the bus drive is released in the same cycle the strobe rises, and the end of a read, where the read-valid pulse comes out in the same idle cycle in which the next request is accepted. The bench holds `req_valid` high across a chain of writes followed by reads, so both collisions occur, and its cycle-by-cycle model predicts every memory pin, the ready signal and the read result in each of those cycles. A pin-level memory model in the bench commits data only at the rising strobe edge, using the lanes and bus value seen just before it, so a drive released early or a lane mis-enabled shows up as wrong data on the later read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_pwr_gate.sv
module sram_pwr_gate #(
  parameter int unsigned PWR_CYC = 10000
) (
  input  logic clk,
  input  logic rst,
  output logic pwr_ok
);
  localparam int unsigned CW = $clog2(PWR_CYC + 1);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
      pwr_ok   <= 1'b0;
    end else if (!pwr_ok) begin
      if (wait_cnt == CW'(PWR_CYC - 1)) pwr_ok <= 1'b1;
      else                              wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // R2: once the wait has ended it never comes back
  p_pwr_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    pwr_ok |=> pwr_ok);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [NB-1:0] lane_en,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= cap_en;
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)         rd_data[g*8 +: 8] <= '0;
      else if (cap_en) rd_data[g*8 +: 8] <= lane_en[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  end

  // R7: read valid is a single-cycle pulse
  p_rdv_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 20,
  parameter int unsigned DW        = 16,
  parameter int unsigned WE_CYC    = 1,
  parameter int unsigned TURN_CYC  = 1,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned RD_CYC    = 1,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_ok,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_mask,
  output logic          req_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [NB-1:0] mem_be_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  output logic          cap_en,
  output logic [NB-1:0] cap_lanes
);
  localparam int unsigned WE_LEN  = max_u(WE_CYC, TURN_CYC + SETUP_CYC);
  localparam int unsigned LEN_MAX = max_u(WE_LEN, RD_CYC);
  localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             sel;
  logic             wr_last, rd_last, accept;

  assign req_ready = (state == ST_IDLE) && pwr_ok;
  assign accept    = req_ready && req_valid;
  assign wr_last   = (state == ST_WRITE) && (cnt == CNT_W'(WE_LEN - 1));
  assign rd_last   = (state == ST_READ)  && (cnt == CNT_W'(RD_CYC - 1));
  assign cap_en    = rd_last;
  assign cap_lanes = ~mem_be_n;
  assign mem_ce_n  = ~sel;
  assign mem_ce    = sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sel        <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= req_write ? ST_WRITE : ST_READ;
            cnt        <= '0;
            sel        <= 1'b1;
            mem_oe_n   <= 1'b0;
            mem_we_n   <= ~req_write;
            mem_be_n   <= ~req_mask;
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            mem_dq_oe  <= req_write && (TURN_CYC == 0);
          end
        end
        ST_WRITE: begin
          if (wr_last) begin
            state     <= ST_IDLE;
            sel       <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= 1'b0;
          end else begin
            cnt       <= cnt + 1'b1;
            mem_dq_oe <= (32'(cnt) + 32'd1 >= TURN_CYC);
          end
        end
        ST_READ: begin
          if (rd_last) begin
            state    <= ST_IDLE;
            sel      <= 1'b0;
            mem_oe_n <= 1'b1;
            mem_be_n <= '1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a lane is enabled only while the part is selected
  p_lane_selected_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_be_n != '1) |-> (!mem_ce_n && mem_ce));
  // R6: the pad drives only inside a write strobe
  p_drive_in_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n);
  // R6: strobe rising releases the bus in the same cycle
  p_release_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> !mem_dq_oe);
  // R5: no drive in the first strobe cycle when a gap is required
  p_turn_gap_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_we_n) && (TURN_CYC != 0)) |-> !mem_dq_oe);
  // R4: address and lanes hold still during the strobe
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));
  // R8: no new request is taken during an access
  p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !req_ready);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int unsigned AW        = 20,
  parameter int unsigned DW        = 16,
  parameter int unsigned PWR_CYC   = 10000,
  parameter int unsigned WE_CYC    = 1,
  parameter int unsigned TURN_CYC  = 1,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned RD_CYC    = 1,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_mask,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [NB-1:0] mem_be_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  logic          pwr_ok;
  logic          cap_en;
  logic [NB-1:0] cap_lanes;

  sram_pwr_gate #(.PWR_CYC(PWR_CYC)) u_pwr (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok)
  );

  sram_seq #(
    .AW(AW), .DW(DW), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC),
    .SETUP_CYC(SETUP_CYC), .RD_CYC(RD_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .req_ready(req_ready),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .cap_en(cap_en), .cap_lanes(cap_lanes)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .lane_en(cap_lanes),
    .dq_in(mem_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R2: nothing is accepted before the power-up wait ends
  p_pwr_blocks_ready_r2: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |-> !req_ready);
  // R1: deselected part has every strobe inactive
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_ce_n && !mem_ce) |-> (mem_we_n && mem_oe_n && !mem_dq_oe));
endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
  localparam int AW = 20, DW = 16, PWR = 300;
  localparam int WE_C = 1, TURN = 1, SETUP = 1, RD = 1;
  localparam int WE_LEN = (WE_C > TURN + SETUP) ? WE_C : TURN + SETUP;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rd_valid, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_be_n;

  always #10 clk = ~clk;

  sram_async_ctrl #(.AW(AW), .DW(DW), .PWR_CYC(PWR), .WE_CYC(WE_C),
    .TURN_CYC(TURN), .SETUP_CYC(SETUP), .RD_CYC(RD)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // pin-level memory: commits on the rising strobe edge
  logic [15:0] pmem [256];
  logic s_we_n = 1, s_oe = 0, s_sel = 0;
  logic [1:0] s_be = 2'b11;
  logic [15:0] s_dq = 0;
  logic [7:0] s_a = 0;

  always_comb begin
    mem_dq_in = 16'hA5A5;
    if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n) begin
      if (!mem_be_n[0]) mem_dq_in[7:0]  = pmem[mem_addr[7:0]][7:0];
      if (!mem_be_n[1]) mem_dq_in[15:8] = pmem[mem_addr[7:0]][15:8];
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) pmem[i] = 16'h0000;
    end else if (s_sel && !s_we_n && mem_we_n) begin
      if (!s_be[0]) pmem[s_a][7:0]  = s_oe ? s_dq[7:0]  : 8'hEE;
      if (!s_be[1]) pmem[s_a][15:8] = s_oe ? s_dq[15:8] : 8'hEE;
    end
    s_we_n = mem_we_n; s_oe = mem_dq_oe; s_sel = !mem_ce_n && mem_ce;
    s_be = mem_be_n; s_dq = mem_dq_out; s_a = mem_addr[7:0];
  end

  // behavioural reference model, advanced on every rising edge
  logic [15:0] mmem [256];
  int m_st = 0, m_cnt = 0, m_pc = 0;
  bit m_pok = 0;
  bit e_sel = 0, e_we_n = 1, e_oe_n = 1, e_dq_oe = 0, e_rdv = 0;
  logic [1:0] e_be_n = 2'b11;
  logic [AW-1:0] e_addr = '0;
  logic [15:0] e_wd = 0, e_rd = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mmem[i] = 16'h0000;
      m_st = 0; m_cnt = 0; m_pc = 0; m_pok = 0;
      e_sel = 0; e_we_n = 1; e_oe_n = 1; e_dq_oe = 0; e_rdv = 0;
      e_be_n = 2'b11; e_addr = '0; e_wd = 0; e_rd = 0;
    end else begin
      automatic bit rdy = (m_st == 0) && m_pok;
      e_rdv = 0;
      if (!m_pok) begin
        if (m_pc == PWR - 1) m_pok = 1; else m_pc++;
      end
      if (m_st == 0) begin
        if (rdy && req_valid) begin
          m_st = req_write ? 1 : 2; m_cnt = 0;
          e_sel = 1; e_oe_n = 0; e_we_n = !req_write; e_be_n = ~req_mask;
          e_addr = req_addr; e_wd = req_wdata;
          e_dq_oe = req_write && (TURN == 0);
        end
      end else if (m_st == 1) begin
        if (m_cnt == WE_LEN - 1) begin
          if (!e_be_n[0]) mmem[e_addr[7:0]][7:0]  = e_wd[7:0];
          if (!e_be_n[1]) mmem[e_addr[7:0]][15:8] = e_wd[15:8];
          m_st = 0; e_sel = 0; e_we_n = 1; e_oe_n = 1; e_be_n = 2'b11; e_dq_oe = 0;
        end else begin
          m_cnt++; e_dq_oe = (m_cnt >= TURN);
        end
      end else begin
        if (m_cnt == RD - 1) begin
          e_rdv = 1;
          e_rd = {e_be_n[1] ? 8'h00 : mmem[e_addr[7:0]][15:8],
                  e_be_n[0] ? 8'h00 : mmem[e_addr[7:0]][7:0]};
          m_st = 0; e_sel = 0; e_oe_n = 1; e_be_n = 2'b11;
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8", req_ready, (m_st == 0) && m_pok);
      chk("R1", {mem_ce_n, mem_ce}, {!e_sel, e_sel});
      chk("R3", mem_be_n, e_be_n);
      chk("R4", mem_we_n, e_we_n);
      chk("R7", mem_oe_n, e_oe_n);
      chk("R5", mem_dq_oe, e_dq_oe);
      chk("R6", mem_dq_oe & mem_we_n, 0);
      if (e_sel) chk("R4", mem_addr, e_addr);
      if (e_dq_oe) chk("R5", mem_dq_out, e_wd);
      chk("R7", rd_valid, e_rdv);
      if (e_rdv) chk("R9", rd_data, e_rd);
    end
  end

  task automatic req(input bit w, input int a, input logic [15:0] d, input logic [1:0] m);
    bit acc;
    req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d; req_mask = m;
    do begin
      acc = req_ready;
      @(negedge clk);
    end while (!acc);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lowcnt = 0;
    repeat (5) @(negedge clk);
    chk("R1", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    rst = 0;
    // R2: request pending from the start, ready must stay low PWR cycles
    req_valid = 1; req_write = 1; req_addr = 20'h10; req_wdata = 16'h1234; req_mask = 2'b11;
    while (!req_ready) begin lowcnt++; @(negedge clk); end
    chk("R2", lowcnt, PWR);
    @(negedge clk);
    idle(3);
    req(0, 'h10, 0, 2'b11); idle(2);
    req(1, 'h10, 16'hAB99, 2'b01); idle(1);           // lower lane only
    req(1, 'h10, 16'h77FF, 2'b10); idle(1);           // upper lane only
    req(0, 'h10, 0, 2'b01); idle(1);
    req(0, 'h10, 0, 2'b10); idle(1);
    req(0, 'h10, 0, 2'b11); idle(1);
    req(1, 'h10, 16'h0000, 2'b00); idle(1);           // R3: no lanes, no change
    req(0, 'h10, 0, 2'b11); idle(1);
    req(0, 'h10, 0, 2'b00); idle(2);                  // R7: all lanes zero
    // back-to-back with valid held high
    for (int i = 0; i < 4; i++) req(1, 'h20 + i, 16'hC000 + 16'(i * 16'h0111), 2'b11);
    for (int i = 0; i < 4; i++) req(0, 'h20 + i, 0, 2'b11);
    req(1, 'h21, 16'h5A5A, 2'b10);
    req(0, 'h21, 0, 2'b11);
    req(0, 'h20, 0, 2'b01);
    idle(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule